// File: doc/BRIEF.md
# Multi-Slice PWM Interrupt and Start Controller

This block is the shared control logic that sits beside a bank of PWM slices. Each slice sends a one-cycle wrap pulse when its counter rolls over. The block latches each pulse into a per-slice raw flag. It combines the raw flags with software force bits and an interrupt mask, and drives a single interrupt line. It also holds the run register, whose bits start and stop the slices. Because one register write can change several run bits at once, a group of slices can be started on the same clock edge so that their counters stay phase-aligned.

Software reaches the registers through a small synchronous port. Every access carries an operation code. A plain write replaces the whole register. A set write ORs ones into it. A clear write removes the ones it carries. Reads are combinational from the address. Bit n of every register belongs to slice n.

Top module: `pwm_irq_ctrl`

## Requirements
- R1: After reset the run, raw, mask and force registers are all zero, every slice run output is low and the interrupt output is low.
- R2: A high level on wrap input bit n at a clock edge sets raw flag n after that edge. The flag stays set until software clears it.
- R3: A write to the raw register (address 1) clears each raw flag whose write-data bit is 1, whatever the operation code. Flags whose write-data bit is 0 keep their value.
- R4: When a wrap pulse for slice n and a clear of raw flag n arrive at the same edge, the flag is set after that edge.
- R5: Reading the raw register returns the latched wrap flags unchanged by the mask or force registers.
- R6: Force bits (address 3) change only through software writes to address 3. Wraps, other writes and interrupt activity leave them as they are.
- R7: The status register (address 4, read-only) reads (raw OR force) AND mask. The interrupt output is high exactly when any status bit is 1, and it follows a register change after the same clock edge.
- R8: Operation code 0 is a plain write, code 1 sets the write-data ones, code 2 clears the write-data ones, and code 3 leaves the register unchanged. These codes apply to the run (address 0), mask (address 2) and force (address 3) registers, so a set or clear touches no other bit.
- R9: A write to the run register changes every affected slice run output on the same clock edge.
- R10: Writes to the status address and to addresses 5 to 7 change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrap_i | input | NSLICE | One-cycle wrap pulses, bit n from slice n |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_op | input | 2 | Write operation: 0 plain, 1 set, 2 clear, 3 none |
| reg_addr | input | AW | Register address (0 run, 1 raw, 2 mask, 3 force, 4 status) |
| reg_wdata | input | NSLICE | Write data |
| reg_rdata | output | NSLICE | Combinational read data for reg_addr |
| slice_run_o | output | NSLICE | Run enables, bit n to slice n |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest case to reach from the ports is a wrap pulse landing on the same edge as a clear of that flag. A real slice only wraps when its counter rolls over, so software cannot line the two up on purpose. The bench drives wrap_i directly, so the vector table can pair a pulse with a clear write in one entry. The table also keeps a force bit set across later wraps, mask changes and clear writes, which shows that only a write to the force register ever changes it.

// File: rtl/pwm_irq_ctrl.sv
module pwm_irq_ctrl #(
  parameter int NSLICE = 8,
  parameter int AW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSLICE-1:0] wrap_i,
  input  logic              reg_wr,
  input  logic [1:0]        reg_op,
  input  logic [AW-1:0]     reg_addr,
  input  logic [NSLICE-1:0] reg_wdata,
  output logic [NSLICE-1:0] reg_rdata,
  output logic [NSLICE-1:0] slice_run_o,
  output logic              irq_o
);

  localparam logic [AW-1:0] A_RUN   = AW'(0);
  localparam logic [AW-1:0] A_RAW   = AW'(1);
  localparam logic [AW-1:0] A_MASK  = AW'(2);
  localparam logic [AW-1:0] A_FORCE = AW'(3);
  localparam logic [AW-1:0] A_STAT  = AW'(4);

  localparam logic [1:0] OP_WR  = 2'd0;
  localparam logic [1:0] OP_SET = 2'd1;
  localparam logic [1:0] OP_CLR = 2'd2;

  logic [NSLICE-1:0] run_q, raw_q, mask_q, force_q;
  logic [NSLICE-1:0] status;
  logic hit_run, hit_raw, hit_mask, hit_force;

  function automatic logic [NSLICE-1:0] apply_op(input logic [1:0] op,
                                                 input logic [NSLICE-1:0] cur,
                                                 input logic [NSLICE-1:0] wd);
    case (op)
      OP_WR:   return wd;
      OP_SET:  return cur | wd;
      OP_CLR:  return cur & ~wd;
      default: return cur;
    endcase
  endfunction

  assign hit_run   = reg_wr && (reg_addr == A_RUN);
  assign hit_raw   = reg_wr && (reg_addr == A_RAW);
  assign hit_mask  = reg_wr && (reg_addr == A_MASK);
  assign hit_force = reg_wr && (reg_addr == A_FORCE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= '0;
      raw_q   <= '0;
      mask_q  <= '0;
      force_q <= '0;
    end else begin
      if (hit_run)   run_q   <= apply_op(reg_op, run_q, reg_wdata);
      if (hit_mask)  mask_q  <= apply_op(reg_op, mask_q, reg_wdata);
      if (hit_force) force_q <= apply_op(reg_op, force_q, reg_wdata);
      raw_q <= (raw_q & ~(hit_raw ? reg_wdata : '0)) | wrap_i;
    end
  end

  assign status      = (raw_q | force_q) & mask_q;
  assign irq_o       = |status;
  assign slice_run_o = run_q;

  always_comb begin
    case (reg_addr)
      A_RUN:   reg_rdata = run_q;
      A_RAW:   reg_rdata = raw_q;
      A_MASK:  reg_rdata = mask_q;
      A_FORCE: reg_rdata = force_q;
      A_STAT:  reg_rdata = status;
      default: reg_rdata = '0;
    endcase
  end

  p_wrap_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|wrap_i) |=> ((raw_q & $past(wrap_i)) == $past(wrap_i)))
    else $error("wrap pulse not latched");

  p_raw_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_raw && !(|wrap_i)) |=> (raw_q == ($past(raw_q) & ~$past(reg_wdata))))
    else $error("raw clear wrong");

  p_wrap_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_raw && (|(wrap_i & reg_wdata))) |=> ((raw_q & $past(wrap_i)) == $past(wrap_i)))
    else $error("clear beat wrap");

  p_force_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_force |=> $stable(force_q))
    else $error("force changed without write");

  p_irq_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(force_q & mask_q)) |-> irq_o)
    else $error("forced unmasked bit without irq");

  p_mask_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_mask && reg_op == OP_SET) |=> ((mask_q & $past(mask_q)) == $past(mask_q)))
    else $error("set write dropped a mask bit");

  p_run_plain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_run && reg_op == OP_WR) |=> (slice_run_o == $past(reg_wdata)))
    else $error("run outputs did not take write");

endmodule

// File: tb/pwm_irq_ctrl_tb.sv
`timescale 1ns/100ps
module pwm_irq_ctrl_tb;
  localparam int N = 8;

  typedef struct packed {
    logic [N-1:0] wrap;
    logic         wr;
    logic [1:0]   op;
    logic [2:0]   addr;
    logic [N-1:0] wd;
    logic [N-1:0] e_raw;
    logic [N-1:0] e_mask;
    logic [N-1:0] e_force;
    logic [N-1:0] e_run;
  } vec_t;

  localparam int NV = 16;
  // wrap, wr, op, addr, wdata, raw, mask, force, run
  localparam vec_t TBL [NV] = '{
    '{8'h05, 1'b0, 2'd0, 3'd0, 8'h00, 8'h05, 8'h00, 8'h00, 8'h00}, // R2
    '{8'h00, 1'b1, 2'd1, 3'd2, 8'h01, 8'h05, 8'h01, 8'h00, 8'h00}, // R8 set, R7
    '{8'h00, 1'b1, 2'd1, 3'd2, 8'h10, 8'h05, 8'h11, 8'h00, 8'h00}, // R8
    '{8'h00, 1'b1, 2'd0, 3'd1, 8'h01, 8'h04, 8'h11, 8'h00, 8'h00}, // R3
    '{8'h04, 1'b1, 2'd0, 3'd1, 8'h04, 8'h04, 8'h11, 8'h00, 8'h00}, // R4
    '{8'h00, 1'b1, 2'd1, 3'd3, 8'h10, 8'h04, 8'h11, 8'h10, 8'h00}, // R6 R7
    '{8'h80, 1'b0, 2'd0, 3'd0, 8'h00, 8'h84, 8'h11, 8'h10, 8'h00}, // R6 R5
    '{8'h00, 1'b1, 2'd2, 3'd2, 8'h10, 8'h84, 8'h01, 8'h10, 8'h00}, // R8 clear
    '{8'h00, 1'b1, 2'd0, 3'd0, 8'h0F, 8'h84, 8'h01, 8'h10, 8'h0F}, // R9
    '{8'h00, 1'b1, 2'd1, 3'd0, 8'h30, 8'h84, 8'h01, 8'h10, 8'h3F}, // R8 on run
    '{8'h00, 1'b1, 2'd1, 3'd1, 8'h00, 8'h84, 8'h01, 8'h10, 8'h3F}, // R3 zeros
    '{8'h00, 1'b1, 2'd3, 3'd2, 8'hFF, 8'h84, 8'h01, 8'h10, 8'h3F}, // R8 op3
    '{8'h00, 1'b1, 2'd0, 3'd5, 8'hFF, 8'h84, 8'h01, 8'h10, 8'h3F}, // R10
    '{8'h00, 1'b1, 2'd2, 3'd3, 8'h10, 8'h84, 8'h01, 8'h00, 8'h3F}, // R6 clear
    '{8'h00, 1'b1, 2'd0, 3'd2, 8'h80, 8'h84, 8'h80, 8'h00, 8'h3F}, // R7
    '{8'h00, 1'b1, 2'd2, 3'd1, 8'h84, 8'h00, 8'h80, 8'h00, 8'h3F}  // R3
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] wrap_i = '0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_op = '0;
  logic [2:0] reg_addr = '0;
  logic [N-1:0] reg_wdata = '0;
  logic [N-1:0] reg_rdata, slice_run_o;
  logic irq_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwm_irq_ctrl #(.NSLICE(N), .AW(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .wrap_i(wrap_i), .reg_wr(reg_wr), .reg_op(reg_op),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .slice_run_o(slice_run_o), .irq_o(irq_o));

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] v);
    reg_addr = a;
    #0.2;
    v = reg_rdata;
  endtask

  task automatic check_state(input string tag, input logic [N-1:0] raw, input logic [N-1:0] msk,
                             input logic [N-1:0] frc, input logic [N-1:0] run);
    logic [N-1:0] v;
    logic [N-1:0] st;
    st = (raw | frc) & msk;
    rd(3'd1, v); chk({tag, " R5 raw"}, v, raw);
    rd(3'd2, v); chk({tag, " R8 mask"}, v, msk);
    rd(3'd3, v); chk({tag, " R6 force"}, v, frc);
    rd(3'd0, v); chk({tag, " R9 run reg"}, v, run);
    chk({tag, " R9 run out"}, slice_run_o, run);
    rd(3'd4, v); chk({tag, " R7 status"}, v, st);
    chk({tag, " R7 irq"}, {{(N-1){1'b0}}, irq_o}, {{(N-1){1'b0}}, |st});
  endtask

  task automatic apply(input vec_t t);
    @(negedge clk);
    wrap_i = t.wrap; reg_wr = t.wr; reg_op = t.op; reg_addr = t.addr; reg_wdata = t.wd;
    @(posedge clk);
    #0.5;
    wrap_i = '0; reg_wr = 1'b0; reg_wdata = '0; reg_op = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wrap_i = '0; reg_wr = 1'b0;
    repeat (2) @(posedge clk);
    #0.5;
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    check_state("R1 reset", 8'h00, 8'h00, 8'h00, 8'h00);

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i]);
      check_state($sformatf("vec%0d", i), TBL[i].e_raw, TBL[i].e_mask, TBL[i].e_force, TBL[i].e_run);
    end

    // R9: several slices start on one edge
    apply('{8'h00, 1'b1, 2'd0, 3'd0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00});
    chk("R9 stopped before group start", slice_run_o, 8'h00);
    @(negedge clk);
    reg_wr = 1'b1; reg_op = 2'd0; reg_addr = 3'd0; reg_wdata = 8'hC3;
    @(posedge clk);
    #0.5;
    reg_wr = 1'b0;
    chk("R9 group start same edge", slice_run_o, 8'hC3);

    // R4 on all bits with force held, then R1 on reset mid-run
    apply('{8'h00, 1'b1, 2'd0, 3'd3, 8'h02, 8'h00, 8'h00, 8'h00, 8'h00});
    apply('{8'hFF, 1'b1, 2'd0, 3'd1, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00});
    check_state("R4 all bits", 8'hFF, 8'h80, 8'h02, 8'hC3);

    do_reset();
    check_state("R1 second reset", 8'h00, 8'h00, 8'h00, 8'h00);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule